// File: doc/BRIEF.md
# Multi-Channel Converter Scan Sequencer

This block runs one complete scan of an analog-to-digital converter each time it is triggered. At the trigger it removes any reserved channels from the requested channel mask. It then converts each remaining channel in turn, lowest index first. For each channel it presents the channel number to the converter and then pulses a start strobe. It polls the converter's completion flag a bounded number of times. After completion it confirms that the converter reports the channel that was asked for. Each 10-bit result is zero-extended into a 16-bit word and stored in a small internal frame store.

A frame leaves the block only when every conversion in the scan has succeeded. The words then appear on consecutive cycles, marked valid, and the final word is flagged as last. If either bounded wait runs out, the block drops the scan at once and pulses a failure flag together with an all-ones sentinel word. No part of that frame is delivered. In private-power operation the converter is woken at each trigger and is given a settling time before the first start. It is put back to sleep after the scan, whether the scan succeeded or failed. In shared-power operation the converter is left powered throughout.

Top module: `adc_scan_seq`

## Requirements
- R1: At the trigger the block latches the effective mask, which is the scan mask ANDed with the inverse of the reserve mask. It converts only those channels, in ascending index order. A trigger whose effective mask is zero is ignored, and busy stays low.
- R2: conv_sel carries the channel for at least one full cycle before conv_start rises. conv_start is a single-cycle pulse, and it is never high while conv_pwr_dn is high.
- R3: conv_done is sampled every POLL_GAP cycles. The k-th sample is taken k*POLL_GAP-1 cycles after the conv_start cycle. When conv_done is still low at sample number POLL_LIMIT, the scan fails. With the defaults (4 and 20), a completion flag that is up 79 cycles after the start cycle passes, and one that is up 80 cycles after it fails.
- R4: After completion, conv_chan_seen is compared with conv_sel using the same interval and the same attempt limit. If it never matches, the scan fails.
- R5: Each output word is the 10-bit conv_data value zero-extended to 16 bits, that is {6'b0, data}.
- R6: A successful scan emits one word per enabled channel, in ascending channel order, on consecutive out_valid cycles. out_last is high with the final word only.
- R7: On failure, scan_fail is high for one cycle and out_data is 16'hFFFF in that cycle. No out_valid is produced for that scan.
- R8: When keep_powered is low, conv_pwr_dn is high while idle. It falls at the trigger, and the first start pulse follows at least WAKE_CYCLES cycles later. It returns high after the scan, on success and on failure alike.
- R9: When keep_powered is high, conv_pwr_dn stays low from the first idle cycle onward. No wake delay is inserted.
- R10: busy is high from the cycle after an accepted trigger until the scan ends. A trigger that arrives while busy is high has no effect.
- R11: After reset, busy, conv_start, out_valid, out_last and scan_fail are low, and conv_pwr_dn is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig | input | 1 | Starts a scan when the block is idle |
| scan_mask | input | NUM_CH | Channels requested for the scan |
| reserve_mask | input | NUM_CH | Channels withheld from scanning |
| keep_powered | input | 1 | High selects shared power (converter never put to sleep) |
| busy | output | 1 | Scan in progress |
| conv_pwr_dn | output | 1 | Converter sleep request |
| conv_sel | output | $clog2(NUM_CH) | Channel presented to the converter |
| conv_start | output | 1 | One-cycle conversion start |
| conv_done | input | 1 | Converter completion flag |
| conv_chan_seen | input | $clog2(NUM_CH) | Channel the converter reports it sampled |
| conv_data | input | RES_W | Conversion result |
| out_valid | output | 1 | Frame word valid |
| out_last | output | 1 | Final word of the frame |
| out_data | output | WORD_W | Frame word, or the sentinel during scan_fail |
| scan_fail | output | 1 | One-cycle scan abort indication |

## Verification
The hardest cases to reach from the ports are the exact edge of the completion poll window and an abort deep inside a scan, after several results are already stored but not yet released. A behavioural converter in the bench takes a programmable latency and can misreport one chosen channel. This places the completion flag exactly one cycle either side of the last permitted sample, and it produces a channel mismatch in the middle of a multi-channel scan. The bench then confirms that the stored partial frame never reaches the output. A second trigger pulsed during a running scan, and a trigger whose request is fully masked by reserved channels, cover the ignore rules.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SEL,
    ST_GO,
    ST_DONE_WAIT,
    ST_MATCH_WAIT,
    ST_SEND
  } scan_state_t;
endpackage

// File: rtl/adc_pick_lowest.sv
module adc_pick_lowest #(
  parameter int W = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

  // R1
  always_comb begin
    pick_hit_chk: assert (!found || req[idx]);
  end
endmodule

// File: rtl/adc_poll_timer.sv
module adc_poll_timer #(
  parameter int GAP   = 4,
  parameter int LIMIT = 20,
  localparam int GAP_W = $clog2(GAP + 1),
  localparam int TRY_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic tick,
  output logic last_try
);
  logic [GAP_W-1:0] gap_cnt;
  logic [TRY_W-1:0] tries;

  assign tick     = run && (gap_cnt == '0);
  assign last_try = (tries == TRY_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      tries   <= '0;
    end else if (load) begin
      gap_cnt <= GAP_W'(GAP - 1);
      tries   <= '0;
    end else if (run) begin
      if (gap_cnt == '0) begin
        gap_cnt <= GAP_W'(GAP - 1);
        if (tries != TRY_W'(LIMIT)) tries <= tries + TRY_W'(1);
      end else begin
        gap_cnt <= gap_cnt - GAP_W'(1);
      end
    end
  end

  // R3
  tries_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run |-> (tries < TRY_W'(LIMIT)));
endmodule

// File: rtl/adc_frame_buf.sv
module adc_frame_buf #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  parameter logic [W-1:0] FAIL_WORD = '1,
  localparam int A_W = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           wr_en,
  input  logic [A_W-1:0] wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           rd_en,
  input  logic [A_W-1:0] rd_addr,
  input  logic           fail_mark,
  output logic [W-1:0]   q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en)          q <= mem[rd_addr];
    else if (fail_mark) q <= FAIL_WORD;
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NUM_CH      = 8,
  parameter int RES_W       = 10,
  parameter int WORD_W      = 16,
  parameter int POLL_GAP    = 4,
  parameter int POLL_LIMIT  = 20,
  parameter int WAKE_CYCLES = 8,
  parameter logic [WORD_W-1:0] FAIL_WORD = '1,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int CNT_W  = $clog2(NUM_CH + 1),
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1),
  localparam int PAD_W  = WORD_W - RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [NUM_CH-1:0] scan_mask,
  input  logic [NUM_CH-1:0] reserve_mask,
  input  logic              keep_powered,
  output logic              busy,
  output logic              conv_pwr_dn,
  output logic [CH_W-1:0]   conv_sel,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [CH_W-1:0]   conv_chan_seen,
  input  logic [RES_W-1:0]  conv_data,
  output logic              out_valid,
  output logic              out_last,
  output logic [WORD_W-1:0] out_data,
  output logic              scan_fail
);
  import adc_scan_pkg::*;

  scan_state_t       state;
  logic [NUM_CH-1:0] pend;
  logic [CNT_W-1:0]  wr_cnt;
  logic [CH_W-1:0]   rd_ptr;
  logic [WAKE_W-1:0] wake_cnt;

  logic [NUM_CH-1:0] eff_mask;
  logic [NUM_CH-1:0] sel_hot;
  logic [NUM_CH-1:0] pend_left;
  logic              pick_found;
  logic [CH_W-1:0]   pick_idx;
  logic              tmr_load, tmr_run, tmr_tick, tmr_last;
  logic              cap_now, fail_now, send_last;

  assign eff_mask  = scan_mask & ~reserve_mask;
  assign sel_hot   = NUM_CH'(1) << conv_sel;
  assign pend_left = pend & ~sel_hot;
  assign busy      = (state != ST_IDLE);
  assign send_last = (CNT_W'(rd_ptr) == wr_cnt - CNT_W'(1));

  adc_pick_lowest #(.W(NUM_CH)) u_pick (
    .req  (pend),
    .found(pick_found),
    .idx  (pick_idx)
  );

  assign tmr_load = (state == ST_GO) ||
                    (state == ST_DONE_WAIT && tmr_tick && conv_done);
  assign tmr_run  = (state == ST_DONE_WAIT) || (state == ST_MATCH_WAIT);

  adc_poll_timer #(.GAP(POLL_GAP), .LIMIT(POLL_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .run     (tmr_run),
    .tick    (tmr_tick),
    .last_try(tmr_last)
  );

  assign cap_now  = (state == ST_MATCH_WAIT) && tmr_tick && (conv_chan_seen == conv_sel);
  assign fail_now = tmr_tick && tmr_last &&
                    (((state == ST_DONE_WAIT) && !conv_done) ||
                     ((state == ST_MATCH_WAIT) && (conv_chan_seen != conv_sel)));

  adc_frame_buf #(.DEPTH(NUM_CH), .W(WORD_W), .FAIL_WORD(FAIL_WORD)) u_buf (
    .clk      (clk),
    .wr_en    (cap_now),
    .wr_addr  (wr_cnt[CH_W-1:0]),
    .wr_data  ({{PAD_W{1'b0}}, conv_data}),
    .rd_en    (state == ST_SEND),
    .rd_addr  (rd_ptr),
    .fail_mark(fail_now),
    .q        (out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pend        <= '0;
      wr_cnt      <= '0;
      rd_ptr      <= '0;
      wake_cnt    <= '0;
      conv_sel    <= '0;
      conv_start  <= 1'b0;
      conv_pwr_dn <= 1'b1;
      out_valid   <= 1'b0;
      out_last    <= 1'b0;
      scan_fail   <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      out_valid  <= 1'b0;
      out_last   <= 1'b0;
      scan_fail  <= 1'b0;
      case (state)
        ST_IDLE: begin
          conv_pwr_dn <= ~keep_powered;
          if (trig && (eff_mask != '0)) begin
            pend   <= eff_mask;
            wr_cnt <= '0;
            rd_ptr <= '0;
            if (keep_powered) begin
              state <= ST_SEL;
            end else begin
              conv_pwr_dn <= 1'b0;
              wake_cnt    <= WAKE_W'(WAKE_CYCLES - 1);
              state       <= ST_WAKE;
            end
          end
        end
        ST_WAKE: begin
          if (wake_cnt == '0) state <= ST_SEL;
          else                wake_cnt <= wake_cnt - WAKE_W'(1);
        end
        ST_SEL: begin
          conv_sel <= pick_idx;
          state    <= pick_found ? ST_GO : ST_IDLE;
        end
        ST_GO: begin
          conv_start <= 1'b1;
          state      <= ST_DONE_WAIT;
        end
        ST_DONE_WAIT: begin
          if (tmr_tick && conv_done) state <= ST_MATCH_WAIT;
        end
        ST_MATCH_WAIT: begin
          if (cap_now) begin
            pend   <= pend_left;
            wr_cnt <= wr_cnt + CNT_W'(1);
            if (pend_left == '0) begin
              conv_pwr_dn <= ~keep_powered;
              state       <= ST_SEND;
            end else begin
              state <= ST_SEL;
            end
          end
        end
        ST_SEND: begin
          out_valid <= 1'b1;
          out_last  <= send_last;
          rd_ptr    <= rd_ptr + CH_W'(1);
          if (send_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
      if (fail_now) begin
        conv_pwr_dn <= ~keep_powered;
        scan_fail   <= 1'b1;
        pend        <= '0;
        state       <= ST_IDLE;
      end
    end
  end

  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  // R2
  start_sel_stable_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(conv_start) |-> $stable(conv_sel));
  // R2
  start_powered_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> !conv_pwr_dn);
  // R6
  last_has_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);
  // R7
  fail_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    scan_fail |-> (!out_valid && out_data == FAIL_WORD));
  // R9
  shared_power_chk: assert property (@(posedge clk) disable iff (rst)
    (keep_powered && $past(keep_powered) && !$past(rst)) |-> !conv_pwr_dn);
endmodule

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH  = 8;
  localparam int WAKE = 8;
  localparam int FAIL_LAT = 80;
  localparam int NV = 8;
  // [31:24] scan mask, [23:16] reserve mask, [15:8] latency, [4] keep, [3:0] bad channel (8 = none)
  localparam logic [31:0] VEC [NV] = '{
    32'hFF00_0308, 32'hA501_0A08, 32'h0F00_0518, 32'h8000_4F08,
    32'h8000_5008, 32'h3C00_0404, 32'h1200_5A18, 32'h3C10_0404
  };

  logic clk = 0, rst = 1, trig = 0, keep_powered = 0;
  logic [7:0] scan_mask = 0, reserve_mask = 0;
  logic busy, conv_pwr_dn, conv_start, conv_done, out_valid, out_last, scan_fail;
  logic [2:0] conv_sel, conv_chan_seen;
  logic [9:0] conv_data;
  logic [15:0] out_data;

  int errors = 0, checks = 0;
  int lat = 3;
  logic [3:0] bad = 4'd8;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst(rst), .trig(trig), .scan_mask(scan_mask),
    .reserve_mask(reserve_mask), .keep_powered(keep_powered), .busy(busy),
    .conv_pwr_dn(conv_pwr_dn), .conv_sel(conv_sel), .conv_start(conv_start),
    .conv_done(conv_done), .conv_chan_seen(conv_chan_seen), .conv_data(conv_data),
    .out_valid(out_valid), .out_last(out_last), .out_data(out_data), .scan_fail(scan_fail)
  );

  function automatic logic [9:0] res_of(input int ch);
    return 10'(ch * 97 + 13);
  endfunction

  // behavioural converter
  int cnt = 0;
  assign conv_chan_seen = ({1'b0, conv_sel} == bad) ? conv_sel + 3'd1 : conv_sel;
  always @(negedge clk) begin
    if (rst) begin
      conv_done = 0; cnt = 0; conv_data = 0;
    end else if (conv_start) begin
      cnt = lat; conv_done = 0; conv_data = res_of(int'(conv_sel));
    end else if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) conv_done = 1;
    end
  end

  // monitor
  logic mon_clr = 0;
  int words_n, last_n, last_pos, fail_n, start_n, breaks, low_run, first_gap, keep_viol;
  logic prev_valid, sent_bad;
  logic [15:0] words [16];
  logic [2:0] start_sel [16];
  always @(negedge clk) begin
    if (mon_clr || rst) begin
      words_n = 0; last_n = 0; last_pos = -1; fail_n = 0; start_n = 0; breaks = 0;
      low_run = 0; first_gap = -1; keep_viol = 0; prev_valid = 0; sent_bad = 0;
    end else begin
      if (out_valid) begin
        if (words_n > 0 && !prev_valid) breaks++;
        if (words_n < 16) words[words_n] = out_data;
        if (out_last) begin last_n++; last_pos = words_n; end
        words_n++;
      end
      prev_valid = out_valid;
      if (scan_fail) begin
        fail_n++;
        if (out_data != 16'hFFFF) sent_bad = 1;
      end
      if (conv_pwr_dn) low_run = 0; else low_run++;
      if (conv_start) begin
        if (start_n == 0) first_gap = low_run - 1;
        if (start_n < 16) start_sel[start_n] = conv_sel;
        start_n++;
      end
      if (keep_powered && conv_pwr_dn) keep_viol++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); mon_clr = 1;
    @(posedge clk); mon_clr = 0;
  endtask

  task automatic fire(input logic [7:0] m, input logic [7:0] r, input logic k);
    @(negedge clk);
    scan_mask = m; reserve_mask = r; keep_powered = k; trig = 1;
    @(negedge clk);
    trig = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_vec(input logic [31:0] v);
    logic [7:0] eff;
    int n, idx;
    bit exp_fail;
    lat = int'(v[15:8]); bad = v[3:0];
    keep_powered = v[4];
    repeat (3) @(negedge clk);
    clear_mon();
    eff = v[31:24] & ~v[23:16];
    n = $countones(eff);
    exp_fail = (lat >= FAIL_LAT) || (bad < 4'd8 && eff[bad[2:0]]);
    fire(v[31:24], v[23:16], v[4]);
    chk(busy == 1'b1, "R10 busy after trigger", busy, 1);
    wait_idle();
    chk(conv_pwr_dn == !v[4], "R8 R9 power after scan", conv_pwr_dn, !v[4]);
    if (!v[4]) chk(first_gap >= WAKE, "R8 wake delay", first_gap, WAKE);
    else       chk(keep_viol == 0, "R9 power held", keep_viol, 0);
    if (exp_fail) begin
      chk(words_n == 0, "R7 no partial frame", words_n, 0);
      chk(fail_n == 1, "R3 R4 R7 fail pulse", fail_n, 1);
      chk(!sent_bad, "R7 sentinel word", sent_bad, 0);
    end else begin
      chk(fail_n == 0, "R3 R4 no fail", fail_n, 0);
      chk(words_n == n, "R6 word count", words_n, n);
      chk(start_n == n, "R1 conversion count", start_n, n);
      chk(last_n == 1 && last_pos == n - 1, "R6 last position", last_pos, n - 1);
      chk(breaks == 0, "R6 consecutive words", breaks, 0);
      idx = 0;
      for (int ch = 0; ch < NCH; ch++) begin
        if (eff[ch] && idx < 16) begin
          chk(start_sel[idx] == 3'(ch), "R1 ascending order", start_sel[idx], ch);
          chk(words[idx] == {6'b0, res_of(ch)}, "R5 word value", words[idx], {6'b0, res_of(ch)});
          idx++;
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(busy == 0, "R11 busy", busy, 0);
    chk(conv_pwr_dn == 1, "R11 pwr_dn", conv_pwr_dn, 1);
    chk(conv_start == 0, "R11 start", conv_start, 0);
    chk(out_valid == 0 && out_last == 0, "R11 out", out_valid, 0);
    chk(scan_fail == 0, "R11 fail", scan_fail, 0);
    rst = 0;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R1: fully reserved request ignored
    keep_powered = 0; lat = 3; bad = 4'd8;
    clear_mon();
    fire(8'h0F, 8'h0F, 1'b0);
    chk(busy == 0, "R1 empty mask ignored", busy, 0);
    repeat (10) @(negedge clk);
    chk(start_n == 0 && conv_pwr_dn == 1, "R1 empty mask no activity", start_n, 0);

    // R10: trigger while busy ignored
    clear_mon();
    fire(8'hFF, 8'h00, 1'b0);
    repeat (20) @(negedge clk);
    trig = 1; scan_mask = 8'h01;
    @(negedge clk); trig = 0;
    wait_idle();
    repeat (20) @(negedge clk);
    chk(start_n == 8, "R10 busy trigger ignored starts", start_n, 8);
    chk(last_n == 1 && words_n == 8, "R10 busy trigger single frame", words_n, 8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule